// File: doc/BRIEF.md
# Serial Peripheral Chip-Select Controller

This unit produces the chip-select lines of a serial-peripheral master. Software programs a small control word through a single-register write/read port. The word picks the line to use, sets the level that counts as "selected", and chooses how the line is driven. In manual mode the selected line follows the written bit directly. In automatic mode a set bit only nominates a line. That line is then driven active for the span of each shift transfer, which an external shift engine marks with a one-cycle start pulse and a one-cycle done pulse.

Only one peripheral is addressed at a time. If software nominates several lines, the lowest-numbered one wins and the others stay inactive. Every output comes from a register. Its new value shows one clock edge after the write or pulse that caused it.

Top module: `spi_csel_ctrl`

## Requirements
- R1: After reset the control word reads 0. Every select output is then high, which is the inactive level for the reset polarity (active low).
- R2: The control word is laid out as follows: bits [1:0] are the per-line select bits, bit 2 is the polarity bit (1 = active high), and bit 3 is the automatic-mode bit. A write stores bits [3:0]. Bits above bit 3 ignore writes and always read 0.
- R3: In manual mode (bit 3 = 0), a line whose select bit is 1 is at its active level and a line whose bit is 0 is at its inactive level. The output takes its new value at the same clock edge that captures the write.
- R4: When more than one select bit is 1, only the lowest-numbered of those lines is active. At most one output is ever at the active level.
- R5: With polarity 0 the active level is 0 and the inactive level is 1. With polarity 1 the levels are swapped. A polarity change appears on the outputs at the edge that captures the write.
- R6: In automatic mode the chosen line is inactive while no transfer is open. It becomes active at the edge that samples the start pulse and returns to inactive at the edge that samples the done pulse, after every transfer.
- R7: A start pulse seen while a transfer is open is ignored. The line stays active until done. A done pulse seen while no transfer is open has no effect.
- R8: In automatic mode with no select bit set, no line becomes active during a transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Write strobe for the control word |
| cfg_wdata | input | DATA_W | Write data |
| cfg_rdata | output | DATA_W | Current control word, upper bits zero |
| xfer_start | input | 1 | One-cycle pulse: shift transfer begins |
| xfer_done | input | 1 | One-cycle pulse: shift transfer ends |
| cs_o | output | NUM_SEL | Chip-select lines |

## Verification
The bench targets the following corner cases, each with the fault it exposes:
- Both select bits set together. A design without the priority pick would drive two peripherals at once.
- A polarity flip while a line is selected. A design that inverted only the active line, or lagged by a cycle, would show a glitch or a stale level.
- A second start inside an open transfer, and a stray done with no transfer open. A design that restarted or toggled its window on these would drop the select early or raise it spuriously.
- Random mixes of writes and pulses, checked against a cycle model. These catch outputs that change one edge too late or that leak reserved write bits into the readback.

// File: rtl/spi_csel_pkg.sv
package spi_csel_pkg;

    parameter int CSEL_NUM = 2;
    localparam int CTRL_W = CSEL_NUM + 2;

    typedef struct packed {
        logic                auto_en;
        logic                act_high;
        logic [CSEL_NUM-1:0] sel;
    } csel_ctrl_t;

endpackage

// File: rtl/spi_csel_regs.sv
module spi_csel_regs
    import spi_csel_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    output csel_ctrl_t        ctrl_d,
    output csel_ctrl_t        ctrl_q,
    output logic [DATA_W-1:0] rdata
);
    localparam logic [DATA_W-1:0] CTRL_MASK = DATA_W'((1 << CTRL_W) - 1);

    csel_ctrl_t nxt_d;
    csel_ctrl_t cur_q;

    always_comb begin
        nxt_d = cur_q;
        if (we) begin
            nxt_d = csel_ctrl_t'(wdata[CTRL_W-1:0]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    always_comb begin
        rdata             = '0;
        rdata[CTRL_W-1:0] = cur_q;
    end

    assign ctrl_d = nxt_d;
    assign ctrl_q = cur_q;

    // R2: a write lands masked to the defined field bits
    p_wr_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (rdata == ($past(wdata) & CTRL_MASK)));

    // R2: reserved bits stay zero
    p_reserved_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rdata[DATA_W-1:CTRL_W] == '0);

endmodule

// File: rtl/spi_csel_window.sv
module spi_csel_window (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic done,
    output logic active_d,
    output logic active_q
);
    typedef struct packed {
        logic open;
    } win_t;

    win_t st_d;
    win_t st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.open) begin
            if (done) begin
                st_d.open = 1'b0;
            end
        end else if (start) begin
            st_d.open = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign active_d = st_d.open;
    assign active_q = st_q.open;

    // R7: start during an open transfer does not end or restart it
    p_start_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.open && start && !done) |=> st_q.open);

    // R6: done always closes an open transfer
    p_done_closes_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.open && done) |=> !st_q.open);

    // R7: done with no transfer open leaves the window closed
    p_stray_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.open && !start) |=> !st_q.open);

endmodule

// File: rtl/spi_csel_drive.sv
module spi_csel_drive
    import spi_csel_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  csel_ctrl_t          ctrl_d,
    input  logic                active_d,
    output logic [CSEL_NUM-1:0] cs_o
);
    typedef struct packed {
        logic [CSEL_NUM-1:0] pin;
    } drv_t;

    logic [CSEL_NUM-1:0] pick;
    logic [CSEL_NUM-1:0] lower_taken;
    logic                enable;
    drv_t                drv_d;
    drv_t                drv_q;

    // lowest-numbered set select bit wins
    assign lower_taken[0] = 1'b0;
    genvar gi;
    generate
        for (gi = 0; gi < CSEL_NUM; gi++) begin : g_pick
            if (gi > 0) begin : g_chain
                assign lower_taken[gi] = lower_taken[gi-1] | ctrl_d.sel[gi-1];
            end
            assign pick[gi] = ctrl_d.sel[gi] & ~lower_taken[gi];
        end
    endgenerate

    assign enable = ctrl_d.auto_en ? active_d : 1'b1;

    always_comb begin
        drv_d = drv_q;
        for (int i = 0; i < CSEL_NUM; i++) begin
            drv_d.pin[i] = (pick[i] & enable) ? ctrl_d.act_high : ~ctrl_d.act_high;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            drv_q.pin <= '1;
        end else begin
            drv_q <= drv_d;
        end
    end

    assign cs_o = drv_q.pin;

    // R4: the priority pick never names more than one line
    p_pick_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pick));

endmodule

// File: rtl/spi_csel_ctrl.sv
module spi_csel_ctrl
    import spi_csel_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int NUM_SEL = CSEL_NUM
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [DATA_W-1:0]  cfg_wdata,
    output logic [DATA_W-1:0]  cfg_rdata,
    input  logic               xfer_start,
    input  logic               xfer_done,
    output logic [NUM_SEL-1:0] cs_o
);
    csel_ctrl_t ctrl_d;
    csel_ctrl_t ctrl_q;
    logic       active_d;
    logic       active_q;

    spi_csel_regs #(.DATA_W(DATA_W)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .ctrl_d(ctrl_d),
        .ctrl_q(ctrl_q),
        .rdata (cfg_rdata)
    );

    spi_csel_window u_win (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (xfer_start),
        .done    (xfer_done),
        .active_d(active_d),
        .active_q(active_q)
    );

    spi_csel_drive u_drv (
        .clk     (clk),
        .rst_n   (rst_n),
        .ctrl_d  (ctrl_d),
        .active_d(active_d),
        .cs_o    (cs_o)
    );

    // R4: at most one output sits at the active level
    p_one_line_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cs_o ^ {NUM_SEL{~ctrl_q.act_high}}));

    // R3: manual mode, line 0 selected follows the active level
    p_manual_follow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_q.auto_en && ctrl_q.sel[0]) |-> (cs_o[0] == ctrl_q.act_high));

    // R6: automatic mode with no open transfer keeps every line inactive
    p_auto_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.auto_en && !active_q) |-> (cs_o == {NUM_SEL{~ctrl_q.act_high}}));

endmodule

// File: tb/spi_csel_ctrl_tb.sv
module spi_csel_ctrl_tb;
    localparam int DW = 32;
    localparam int NS = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [DW-1:0] cfg_wdata = '0;
    logic [DW-1:0] cfg_rdata;
    logic          xfer_start = 1'b0;
    logic          xfer_done = 1'b0;
    logic [NS-1:0] cs_o;

    int n_chk = 0;
    int n_err = 0;
    logic [3:0] m_ctrl = '0;
    logic       m_open = 1'b0;
    bit         wd_hit = 1'b0;

    always #5 clk = ~clk;

    spi_csel_ctrl #(.DATA_W(DW), .NUM_SEL(NS)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .xfer_start(xfer_start), .xfer_done(xfer_done),
        .cs_o(cs_o)
    );

    function automatic logic [NS-1:0] exp_cs(logic [3:0] c, logic open);
        logic [NS-1:0] r;
        logic en;
        bit taken;
        en = c[3] ? open : 1'b1;
        taken = 0;
        for (int i = 0; i < NS; i++) begin
            r[i] = ~c[2];
            if (c[i] && !taken) begin
                taken = 1;
                if (en) r[i] = c[2];
            end
        end
        return r;
    endfunction

    task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(bit we, logic [DW-1:0] wd, bit st, bit dn);
        cfg_we = we; cfg_wdata = wd; xfer_start = st; xfer_done = dn;
        @(posedge clk);
        if (we) m_ctrl = wd[3:0];
        m_open = m_open ? !dn : st;
        @(negedge clk);
        cfg_we = 0; xfer_start = 0; xfer_done = 0;
    endtask

    task automatic chk_out(string req);
        check(req, DW'(cs_o), DW'(exp_cs(m_ctrl, m_open)));
    endtask

    initial begin
        #2000000;
        wd_hit = 1;
    end

    initial begin : main
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        check("R1 rdata", cfg_rdata, '0);
        check("R1 cs", DW'(cs_o), DW'(2'b11));
        rst_n = 1;
        @(negedge clk);
        // R2: reserved bits dropped
        step(1, 32'hFFFF_FFF0 | 32'h5, 0, 0);
        check("R2 readback", cfg_rdata, 32'h5);
        // R3 manual select line 1, low active
        step(1, 32'h2, 0, 0);
        check("R3 line1", DW'(cs_o), DW'(2'b01));
        // R4 both bits
        step(1, 32'h3, 0, 0);
        check("R4 both", DW'(cs_o), DW'(2'b10));
        // R5 polarity flip
        step(1, 32'h7, 0, 0);
        check("R5 high", DW'(cs_o), DW'(2'b01));
        step(1, 32'h6, 0, 0);
        check("R5 high line1", DW'(cs_o), DW'(2'b10));
        // R6 auto mode, line 0, active low
        step(1, 32'h9, 0, 0);
        check("R6 idle", DW'(cs_o), DW'(2'b11));
        step(0, 0, 1, 0);
        check("R6 start", DW'(cs_o), DW'(2'b10));
        // R7 second start ignored
        step(0, 0, 1, 0);
        check("R7 restart", DW'(cs_o), DW'(2'b10));
        step(0, 0, 0, 1);
        check("R6 done", DW'(cs_o), DW'(2'b11));
        // R7 stray done
        step(0, 0, 0, 1);
        check("R7 stray done", DW'(cs_o), DW'(2'b11));
        step(0, 0, 1, 0);
        check("R6 again", DW'(cs_o), DW'(2'b10));
        step(0, 0, 0, 1);
        check("R6 again end", DW'(cs_o), DW'(2'b11));
        // R8 auto with nothing selected
        step(1, 32'hC, 0, 0);
        step(0, 0, 1, 0);
        check("R8 none", DW'(cs_o), DW'(2'b00));
        step(0, 0, 0, 1);
        // random mix
        for (int k = 0; k < 400; k++) begin
            logic [DW-1:0] wd;
            bit we;
            wd = $urandom();
            we = ($urandom() % 4) == 0;
            step(we, wd, ($urandom() % 3) == 0, ($urandom() % 3) == 0);
            chk_out("R3/R4/R5/R6 random");
            check("R2 random rdata", cfg_rdata, DW'(m_ctrl));
            if (wd_hit) break;
        end
        if (wd_hit) begin
            n_chk++; n_err++;
            $display("FAIL watchdog actual=expired expected=done");
        end
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule